// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block fetches transmit work from a ring of four-word descriptors held in a shared memory and turns each buffer into a byte stream for a MAC transmitter. Software fills a buffer, writes its length and address into a descriptor, and sets the ownership bit in the descriptor's control word. The engine then reads the buffer one 32-bit word at a time and streams its bytes to the MAC under a valid/ready handshake. Frame start and frame end markers come from the segment flags. When the buffer has been sent, the engine writes the control word back with ownership cleared and moves to the next descriptor.

The engine stops at the first descriptor it does not own, raises a suspended status bit and waits. A pulse on the poll-demand input makes it read that same descriptor again. The engine also records two events in status: a completed descriptor that asked for an interrupt, and a frame that ran out of owned descriptors before its last segment (an underflow). Software clears status bits by writing ones to them.

Top module: `txd_ring_dma`

## Requirements
- R1: After synchronous reset, `status` is 0. `tx_valid`, `rd_en` and `wr_en` are low, and the descriptor pointer equals `ring_base`.
- R2: When the control word (descriptor word 0) has bit 31 (owner) clear, the engine sets status bit 2 (suspended) and emits no bytes. It stays idle until a poll demand arrives.
- R3: A `poll_demand` pulse while the engine is idle restarts the fetch at the same descriptor where it stopped. A pulse while the engine is busy is ignored.
- R4: The engine emits exactly the byte count held in bits 12:0 of word 1. The bytes are read from the byte address in word 2, lowest byte lane of each 32-bit word first.
- R5: `tx_sof` marks the first byte of a buffer whose word 0 bit 28 (first segment) is set. `tx_eof` marks the final byte of a buffer whose word 0 bit 29 (last segment) is set. Neither marker is asserted on any other byte.
- R6: After a buffer has been sent, word 0 is written back unchanged except that bit 31 is cleared.
- R7: When word 0 bit 20 (chained) is set, the next descriptor is at the address held in word 3. When bit 20 is clear, the next descriptor is at the current address plus 16, and word 3 is ignored.
- R8: Completing a descriptor whose word 0 bit 30 is set sets status bit 0 (transmit done).
- R9: Finding a descriptor that is not owned, while a frame has been started without its last segment, sets status bit 5 (underflow) together with bit 2. The partial frame is abandoned.
- R10: Writing a one to a bit of `status_w1c` clears that status bit and leaves the others as they are. When the engine sets a bit in the same cycle that it is cleared, the set wins.
- R11: A buffer with byte count 0 produces no bytes, but it is still written back and advanced past.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data`, `tx_sof` and `tx_eof` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Byte address of the first descriptor, loaded at reset |
| poll_demand | input | 1 | One-cycle pulse that restarts fetch while idle |
| status_w1c | input | 6 | Write-one-to-clear mask for status |
| status | output | 6 | Bit 0 transmit done, bit 2 suspended, bit 5 underflow |
| rd_en | output | 1 | Memory read strobe; data is returned one cycle later |
| rd_addr | output | AW | Memory read byte address (word aligned) |
| rd_data | input | 32 | Memory read data |
| wr_en | output | 1 | Memory write strobe for descriptor writeback |
| wr_addr | output | AW | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| tx_ready | input | 1 | MAC accepts the current byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |

## Verification
A software clear of the suspended bit can land in the same cycle in which the engine sets that bit on meeting a descriptor it does not own. The bench provokes this by holding the clear mask for bit 2 high across a whole poll of a descriptor it has not handed over. It then looks at every falling edge for bit 2 to show as one. The bit can show only in the cycle where set beat the held clear, and the bench then confirms that the bit clears once the mask has done its work. In the same way, the writeback of one descriptor and the fetch of the next could both claim the memory port. An assertion forbids a read and a write in the same cycle.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // control word bit positions (word 0)
  localparam int W0_OWN = 31;
  localparam int W0_IOC = 30;
  localparam int W0_LS  = 29;
  localparam int W0_FS  = 28;
  localparam int W0_CH  = 20;

  // status bit positions
  localparam int STATUS_W = 6;
  localparam int ST_TI    = 0;
  localparam int ST_TBU   = 2;
  localparam int ST_UNF   = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_RD4,
    S_BREQ, S_BLD, S_BOUT, S_WB
  } fsm_e;
endpackage

// File: rtl/txd_status.sv
module txd_status #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  // set takes priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= (status_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/txd_byte_ser.sv
module txd_byte_ser #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word,
  input  logic [$clog2(DW/8+1)-1:0] nbytes,
  input  logic          mark_first,
  input  logic          mark_last,
  input  logic          ready,
  output logic          valid,
  output logic [7:0]    data,
  output logic          sof,
  output logic          eof,
  output logic          done
);
  localparam int NB = DW / 8;
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(NB + 1);

  logic [DW-1:0] word_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, first_q, last_q;
  logic [DW-1:0] shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      word_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (load) begin
      busy_q  <= 1'b1;
      word_q  <= word;
      idx_q   <= '0;
      cnt_q   <= nbytes;
      first_q <= mark_first;
      last_q  <= mark_last;
    end else if (busy_q && ready) begin
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign shifted = word_q >> {idx_q, 3'b000};
  assign valid   = busy_q;
  assign data    = shifted[7:0];
  assign sof     = busy_q && first_q && (idx_q == '0);
  assign eof     = busy_q && last_q && (cnt_q == CW'(1));
  assign done    = busy_q && ready && (cnt_q == CW'(1));
endmodule

// File: rtl/txd_ring_dma.sv
module txd_ring_dma
  import txd_pkg::*;
#(
  parameter int AW    = 12,
  parameter int LEN_W = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       ring_base,
  input  logic                poll_demand,
  input  logic [STATUS_W-1:0] status_w1c,
  output logic [STATUS_W-1:0] status,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  input  logic [31:0]         rd_data,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [31:0]         wr_data,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_sof,
  output logic                tx_eof
);
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int CW = $clog2(NB + 1);
  localparam logic [AW-1:0] WSTEP  = AW'(NB);
  localparam logic [AW-1:0] DSTEP  = AW'(4 * NB);

  fsm_e              state_q;
  logic [AW-1:0]     desc_q, buf_q, next_q;
  logic [DW-1:0]     ctrl_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CW-1:0]     chunk_q, chunk;
  logic              in_frame_q, sof_pend_q;
  logic [STATUS_W-1:0] st_set;
  logic              ser_load, ser_done;
  logic              not_owned;

  assign chunk     = (rem_q >= LEN_W'(NB)) ? CW'(NB) : CW'(rem_q);
  assign not_owned = (state_q == S_RD1) && !rd_data[W0_OWN];
  assign ser_load  = (state_q == S_BLD);

  // memory port
  always_comb begin
    rd_en   = 1'b1;
    rd_addr = desc_q;
    unique case (state_q)
      S_RD0:   rd_addr = desc_q;
      S_RD1:   rd_addr = desc_q + WSTEP;
      S_RD2:   rd_addr = desc_q + 2 * WSTEP;
      S_RD3:   rd_addr = desc_q + 3 * WSTEP;
      S_BREQ:  rd_addr = buf_q;
      default: rd_en   = 1'b0;
    endcase
  end

  assign wr_en   = (state_q == S_WB);
  assign wr_addr = desc_q;
  assign wr_data = ctrl_q & ~(DW'(1) << W0_OWN);

  always_comb begin
    st_set         = '0;
    st_set[ST_TI]  = (state_q == S_WB) && ctrl_q[W0_IOC];
    st_set[ST_TBU] = not_owned;
    st_set[ST_UNF] = not_owned && in_frame_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      desc_q     <= ring_base;
      buf_q      <= '0;
      next_q     <= '0;
      ctrl_q     <= '0;
      rem_q      <= '0;
      chunk_q    <= '0;
      in_frame_q <= 1'b0;
      sof_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (poll_demand) state_q <= S_RD0;
        S_RD0:  state_q <= S_RD1;
        S_RD1: begin
          if (!rd_data[W0_OWN]) begin
            in_frame_q <= 1'b0;
            state_q    <= S_IDLE;
          end else begin
            ctrl_q  <= rd_data;
            state_q <= S_RD2;
          end
        end
        S_RD2: begin
          rem_q   <= rd_data[LEN_W-1:0];
          state_q <= S_RD3;
        end
        S_RD3: begin
          buf_q   <= rd_data[AW-1:0];
          state_q <= S_RD4;
        end
        S_RD4: begin
          next_q     <= rd_data[AW-1:0];
          sof_pend_q <= ctrl_q[W0_FS];
          state_q    <= (rem_q == '0) ? S_WB : S_BREQ;
        end
        S_BREQ: state_q <= S_BLD;
        S_BLD: begin
          chunk_q    <= chunk;
          sof_pend_q <= 1'b0;
          state_q    <= S_BOUT;
        end
        S_BOUT: begin
          if (ser_done) begin
            rem_q <= rem_q - LEN_W'(chunk_q);
            if (rem_q == LEN_W'(chunk_q)) begin
              state_q <= S_WB;
            end else begin
              buf_q   <= buf_q + WSTEP;
              state_q <= S_BREQ;
            end
          end
        end
        S_WB: begin
          desc_q     <= ctrl_q[W0_CH] ? next_q : desc_q + DSTEP;
          in_frame_q <= !ctrl_q[W0_LS];
          state_q    <= S_RD0;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  txd_byte_ser #(.DW(DW)) ser_i (
    .clk        (clk),
    .rst        (rst),
    .load       (ser_load),
    .word       (rd_data),
    .nbytes     (chunk),
    .mark_first (sof_pend_q),
    .mark_last  (ctrl_q[W0_LS] && (rem_q <= LEN_W'(NB))),
    .ready      (tx_ready),
    .valid      (tx_valid),
    .data       (tx_data),
    .sof        (tx_sof),
    .eof        (tx_eof),
    .done       (ser_done)
  );

  txd_status #(.W(STATUS_W)) status_i (
    .clk      (clk),
    .rst      (rst),
    .set_i    (st_set),
    .clr_i    (status_w1c),
    .status_o (status)
  );
endmodule

// File: rtl/txd_ring_dma_chk.sv
module txd_ring_dma_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] status,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof,
  input logic       rd_en,
  input logic       wr_en,
  input logic       wb_own
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (status == 6'd0 && !tx_valid && !rd_en && !wr_en)); // R1

  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> !tx_valid); // R2

  AST_MARKERS_VALID: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid); // R5

  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R6

  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !wb_own); // R6

  AST_UNF_SUSPENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(status[5]) |-> status[2]); // R9

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof))); // R12
endmodule

bind txd_ring_dma txd_ring_dma_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .status   (status),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_sof   (tx_sof),
  .tx_eof   (tx_eof),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wb_own   (wr_data[31])
);

// File: tb/txd_ring_dma_tb.sv
module txd_ring_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ring_base = 12'h000;
  logic        poll_demand = 1'b0;
  logic [5:0]  status_w1c = 6'd0;
  logic [5:0]  status;
  logic        rd_en, wr_en;
  logic [11:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic        tx_ready = 1'b1;
  logic        tx_valid, tx_sof, tx_eof;
  logic [7:0]  tx_data;

  always #5 clk = ~clk;

  txd_ring_dma #(.AW(12), .LEN_W(13)) dut_i (
    .clk(clk), .rst(rst), .ring_base(ring_base), .poll_demand(poll_demand),
    .status_w1c(status_w1c), .status(status),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  // memory model, one-cycle read latency
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [11:0] tb_waddr = '0;
  logic [31:0] tb_wdata = '0;
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[11:2]];
    if (wr_en) mem[wr_addr[11:2]] <= wr_data;
    else if (tb_we) mem[tb_waddr[11:2]] <= tb_wdata;
  end

  // byte monitor
  logic [7:0] cap_d [0:255];
  logic       cap_s [0:255];
  logic       cap_e [0:255];
  int         ncap = 0;
  int         hold_viol = 0;
  logic       pv_stall = 1'b0;
  logic [7:0] pv_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (pv_stall && (!tx_valid || tx_data != pv_data)) hold_viol <= hold_viol + 1;
      pv_stall <= tx_valid && !tx_ready;
      pv_data  <= tx_data;
      if (tx_valid && tx_ready) begin
        cap_d[ncap[7:0]] <= tx_data;
        cap_s[ncap[7:0]] <= tx_sof;
        cap_e[ncap[7:0]] <= tx_eof;
        ncap <= ncap + 1;
      end
    end
  end

  // ready pattern with stalls
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k = k + 1;
      tx_ready = (k % 3) != 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic poke(int addr, logic [31:0] v);
    @(negedge clk); tb_we = 1'b1; tb_waddr = 12'(addr); tb_wdata = v;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
  endtask

  task automatic clear(logic [5:0] m);
    @(negedge clk); status_w1c = m;
    @(negedge clk); status_w1c = 6'd0;
  endtask

  task automatic wait_susp(string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status[2]) return;
    end
    chk(req, "suspend reached", 0, 1);
  endtask

  // expected stream
  logic [7:0] exp_d [0:255];
  logic       exp_s [0:255];
  logic       exp_e [0:255];
  int         nexp;
  logic [31:0] exp_w0 [0:3];
  int          cur = 0;

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 13 + k * 7 + 1) & 255);
  endfunction

  // build one descriptor at ring slot cur and advance cur
  task automatic put_desc(bit fs, bit ls, bit ioc, int len, int seed);
    int base = cur * 16;
    int bufa = 12'h400 + cur * 12'h100;
    bit ch   = (cur == 3);
    logic [31:0] w0;
    w0 = (32'd1 << 31) | (32'(ioc) << 30) | (32'(ls) << 29) | (32'(fs) << 28) | (32'(ch) << 20);
    for (int w = 0; w < (len + 3) / 4; w++)
      poke(bufa + 4 * w, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
    for (int k = 0; k < len; k++) begin
      exp_d[nexp] = pat(seed, k);
      exp_s[nexp] = fs && (k == 0);
      exp_e[nexp] = ls && (k == len - 1);
      nexp++;
    end
    poke(base + 4, 32'(len));
    poke(base + 8, 32'(bufa));
    poke(base + 12, ch ? 32'h0 : 32'h3F0); // R7: word 3 ignored unless chained
    poke(base, w0);
    exp_w0[cur] = w0 & ~(32'd1 << 31);
    cur = (cur + 1) % 4;
  endtask

  task automatic compare_stream(int base, string tag);
    chk("R4", {tag, " byte count"}, ncap - base, nexp);
    for (int k = 0; k < nexp && k < ncap - base; k++) begin
      chk("R4", {tag, " byte"}, cap_d[8'(base + k)], exp_d[k]);
      chk("R5", {tag, " sof"}, cap_s[8'(base + k)], exp_s[k]);
      chk("R5", {tag, " eof"}, cap_e[8'(base + k)], exp_e[k]);
    end
  endtask

  initial begin
    int base;
    int first;
    for (int i = 0; i < 4; i++) poke(i * 16, 32'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "status after reset", status, 0);
    chk("R1", "tx_valid after reset", tx_valid, 0);
    chk("R1", "rd_en idle", rd_en, 0);
    chk("R1", "wr_en idle", wr_en, 0);

    // nothing owned: suspend, no bytes
    base = ncap;
    pulse_poll();
    wait_susp("R2");
    chk("R2", "status when nothing owned", status, 6'h04);
    chk("R2", "bytes when nothing owned", ncap - base, 0);
    clear(6'h04);
    chk("R10", "w1c clears suspend", status, 0);

    // sweep single-segment frames, lengths 1..9, ring wraps twice
    for (int len = 1; len <= 9; len++) begin
      int slot = cur;
      nexp = 0;
      base = ncap;
      put_desc(1'b1, 1'b1, len[0], len, len);
      clear(6'h3F);
      pulse_poll();
      wait_susp("R3");
      compare_stream(base, "single");
      chk("R6", "writeback word 0", mem[slot * 4], exp_w0[slot]);
      chk("R8", "done bit follows ioc", status[0], len[0]);
      chk("R2", "suspended after frame", status[2], 1);
      chk("R9", "no underflow on whole frame", status[5], 0);
    end

    // three-segment frame: markers only at frame edges, R7 across the ring
    nexp = 0;
    base = ncap;
    first = cur;
    put_desc(1'b1, 1'b0, 1'b0, 5, 40);
    put_desc(1'b0, 1'b0, 1'b0, 3, 41);
    put_desc(1'b0, 1'b1, 1'b1, 6, 42);
    clear(6'h3F);
    pulse_poll();
    wait_susp("R7");
    compare_stream(base, "multi");
    for (int j = 0; j < 3; j++)
      chk("R6", "multi writeback", mem[((first + j) % 4) * 4], exp_w0[(first + j) % 4]);
    chk("R8", "done after last segment", status, 6'h05);

    // zero-length buffer
    nexp = 0;
    base = ncap;
    first = cur;
    put_desc(1'b1, 1'b1, 1'b1, 0, 50);
    clear(6'h3F);
    pulse_poll();
    wait_susp("R11");
    chk("R11", "zero length bytes", ncap - base, 0);
    chk("R11", "zero length writeback", mem[first * 4], exp_w0[first]);
    chk("R11", "zero length done bit", status[0], 1);

    // underflow: first segment without a following owned descriptor
    nexp = 0;
    base = ncap;
    put_desc(1'b1, 1'b0, 1'b0, 4, 60);
    clear(6'h3F);
    pulse_poll();
    wait_susp("R9");
    compare_stream(base, "underflow");
    chk("R9", "underflow status", status, 6'h24);
    clear(6'h20);
    chk("R10", "selective clear keeps suspend", status, 6'h04);

    // resume at the same slot after poll
    nexp = 0;
    base = ncap;
    put_desc(1'b0, 1'b1, 1'b0, 2, 61);
    clear(6'h3F);
    pulse_poll();
    wait_susp("R3");
    compare_stream(base, "resume");
    chk("R9", "no underflow after resume", status[5], 0);

    // poll during an active frame is ignored: engine still completes once
    nexp = 0;
    base = ncap;
    put_desc(1'b1, 1'b1, 1'b0, 8, 70);
    clear(6'h3F);
    pulse_poll();
    pulse_poll();
    wait_susp("R3");
    compare_stream(base, "busy poll");

    // set and clear of suspend in the same cycle
    begin
      bit seen = 1'b0;
      clear(6'h3F);
      @(negedge clk); status_w1c = 6'h04;
      pulse_poll();
      for (int i = 0; i < 200 && !seen; i++) begin
        @(negedge clk);
        if (status[2]) seen = 1'b1;
      end
      chk("R10", "set wins over same-cycle clear", seen, 1);
      @(negedge clk);
      chk("R10", "held clear removes bit", status[2], 0);
      status_w1c = 6'd0;
    end

    chk("R12", "stalled byte held", hold_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule